// File: doc/BRIEF.md
# Paged Direct Address Generator

This block turns the short operand offset held in the low byte of an instruction into a full data-memory address. Bit 7 of that byte must be clear for the byte to count as a direct reference. Bits 6:0 are an unsigned offset. A two-bit mode input picks how the offset is combined with a base register.

In direct mode, a stored stack-select bit chooses the base. When the bit is 0, the offset is appended below a 9-bit page register, which gives 512 pages of 128 words. When the bit is 1, the offset is added to a 16-bit stack pointer. Register mode ignores every base and confines the address to the lowest 128 words. Peripheral mode appends the offset below a separate 9-bit I/O page register. Extended mode adds the offset to the low 16 bits of a 23-bit pointer and carries the top 7 bits through unchanged.

The result is registered. It appears one cycle after an accepted request, together with a tag that names the target space. The address stays held until the next accepted request.

Top module: `dpage_addr_gen`

## Requirements
- R1: While reset is low at a clock edge, the next cycle shows `addr_valid`=0, `addr`=0, `addr_space`=0, and the stack-select bit is 0.
- R2: With `amode`=2'b00 and the stack-select bit at 0, `addr` = {7'b0, `page_reg`, offset}. For example, page 2 with offset 1 gives 0x000101. The space is data (2'b00).
- R3: With `amode`=2'b00 and the stack-select bit at 1, `addr` = {7'b0, (`stk_ptr` + zero-extended offset) mod 2^16}. Any carry out of the sum is discarded. The space is data.
- R4: A cycle with `sel_wr`=1 loads `sel_val` into the stack-select bit. A request made in that same cycle still uses the previous value of the bit; the new value applies from the next cycle on.
- R5: With `amode`=2'b01, `addr` = {16'b0, offset} and the space is register (2'b01). The page register, the stack pointer and the stack-select bit have no effect. Offsets 0x00–0x5F reach registers and 0x60–0x7F reach scratch memory.
- R6: With `amode`=2'b10, `addr` = {7'b0, `io_page`, offset} and the space is I/O (2'b10).
- R7: With `amode`=2'b11, `addr[22:16]` = `ext_ptr[22:16]` and `addr[15:0]` = (`ext_ptr[15:0]` + offset) mod 2^16. The space is data.
- R8: A request whose `instr_lo[7]` is 1 is not accepted. The next cycle shows `addr_valid`=0, and `addr` and `addr_space` keep their previous values.
- R9: `addr_valid` is 1 exactly in the cycle after an accepted request (`req_valid`=1, `instr_lo[7]`=0). In a cycle with no request, the next cycle shows `addr_valid`=0 and the address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Address request this cycle |
| instr_lo | input | 8 | Instruction low byte: bit 7 is the direct marker (0), bits 6:0 are the offset |
| amode | input | 2 | 00 direct, 01 register, 10 peripheral, 11 extended |
| sel_wr | input | 1 | Load the stack-select bit |
| sel_val | input | 1 | Value to load into the stack-select bit |
| page_reg | input | 9 | Data page register |
| stk_ptr | input | 16 | Stack pointer |
| io_page | input | 9 | Peripheral page register |
| ext_ptr | input | 23 | Extended page pointer |
| addr_valid | output | 1 | Address valid this cycle |
| addr | output | 23 | Generated address |
| addr_space | output | 2 | 00 data, 01 register, 10 I/O |

## Verification
The bench builds the block with its default parameters: a 7-bit offset, a 16-bit low word and a 23-bit address. With these values, the highest page (0x1FF) and the full 0x7F offset can be driven directly. They also allow a stack pointer and an extended low word close enough to 0xFFFF to force the 16-bit wrap. The scoreboard checks that the top 7 bits pass through in extended mode and stay zero in stack mode, including when the low sum wraps. It also drives a stack-select write in the same cycle as a request, to check when the new bit takes effect.

// File: rtl/dpage_pkg.sv
// Shared encodings for the paged direct address generator.
// Assumes: the mode and space codes below are fixed at the block's ports.
package dpage_pkg;
    typedef enum logic [1:0] {
        AM_DIRECT = 2'b00,
        AM_REGS   = 2'b01,
        AM_PERIPH = 2'b10,
        AM_EXT    = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        SPC_DATA = 2'b00,
        SPC_REGS = 2'b01,
        SPC_IO   = 2'b10
    } space_e;
endpackage

// File: rtl/dpage_field_decode.sv
// Splits the instruction low byte into the direct marker and the offset.
// Assumes: the marker sits directly above the offset field.
module dpage_field_decode #(
    parameter int OFS_W = 7
) (
    input  logic             req_valid,
    input  logic [OFS_W:0]   instr_lo,
    output logic             accept,
    output logic [OFS_W-1:0] ofs
);
    // Accept only requests whose marker bit is clear.
    always_comb begin
        accept = req_valid && !instr_lo[OFS_W];
        ofs    = instr_lo[OFS_W-1:0];
    end
endmodule

// File: rtl/dpage_addr_calc.sv
// Combinational address former for all four modes.
// Assumes: the offset is unsigned, and every low-word sum wraps modulo 2^LO_W.
module dpage_addr_calc
    import dpage_pkg::*;
#(
    parameter int OFS_W  = 7,
    parameter int LO_W   = 16,
    parameter int ADDR_W = 23
) (
    input  logic [1:0]         mode,
    input  logic               stk_sel,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [LO_W-OFS_W-1:0] page_reg,
    input  logic [LO_W-1:0]    stk_ptr,
    input  logic [LO_W-OFS_W-1:0] io_page,
    input  logic [ADDR_W-1:0]  ext_ptr,
    output logic [ADDR_W-1:0]  addr_nx,
    output logic [1:0]         space_nx
);
    localparam int HI_W  = ADDR_W - LO_W;
    localparam int PAD_W = LO_W - OFS_W;

    logic [LO_W-1:0] ofs_ext;
    logic [LO_W-1:0] stk_sum;
    logic [LO_W-1:0] ext_sum;

    // Zero-extend the offset and form the two wrapping low-word sums.
    always_comb begin
        ofs_ext = {{PAD_W{1'b0}}, ofs};
        stk_sum = stk_ptr + ofs_ext;
        ext_sum = ext_ptr[LO_W-1:0] + ofs_ext;
    end

    // Select the address and its space tag by mode.
    always_comb begin
        addr_nx  = '0;
        space_nx = SPC_DATA;
        case (amode_e'(mode))
            AM_DIRECT: begin
                if (stk_sel) addr_nx = {{HI_W{1'b0}}, stk_sum};
                else         addr_nx = {{HI_W{1'b0}}, page_reg, ofs};
            end
            AM_REGS: begin
                addr_nx  = {{(ADDR_W-OFS_W){1'b0}}, ofs};
                space_nx = SPC_REGS;
            end
            AM_PERIPH: begin
                addr_nx  = {{HI_W{1'b0}}, io_page, ofs};
                space_nx = SPC_IO;
            end
            default: begin
                addr_nx = {ext_ptr[ADDR_W-1:LO_W], ext_sum};
            end
        endcase
    end
endmodule

// File: rtl/dpage_out_reg.sv
// Output stage: captures address and space on an accepted request, else holds.
// Assumes: synchronous active-low reset clears all outputs.
module dpage_out_reg #(
    parameter int ADDR_W = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_d,
    input  logic [1:0]        space_d,
    output logic              valid_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [1:0]        space_q
);
    // Register the result; hold the address between accepted requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            addr_q  <= '0;
            space_q <= 2'b00;
        end else begin
            valid_q <= load;
            if (load) begin
                addr_q  <= addr_d;
                space_q <= space_d;
            end
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> (!valid_q && $stable(addr_q) && $stable(space_q))); // R8

    AST_REGS_LOW_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && space_q == 2'b01) |-> (addr_q >> 7) == '0); // R5
endmodule

// File: rtl/dpage_addr_gen.sv
// Top: paged direct address generator. Holds the stack-select bit, decodes
// the instruction byte, forms the address and registers it.
// Assumes: base registers are stable in the request cycle; offset width 7.
module dpage_addr_gen
    import dpage_pkg::*;
#(
    parameter int OFS_W  = 7,
    parameter int LO_W   = 16,
    parameter int ADDR_W = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [OFS_W:0]        instr_lo,
    input  logic [1:0]            amode,
    input  logic                  sel_wr,
    input  logic                  sel_val,
    input  logic [LO_W-OFS_W-1:0] page_reg,
    input  logic [LO_W-1:0]       stk_ptr,
    input  logic [LO_W-OFS_W-1:0] io_page,
    input  logic [ADDR_W-1:0]     ext_ptr,
    output logic                  addr_valid,
    output logic [ADDR_W-1:0]     addr,
    output logic [1:0]            addr_space
);
    localparam int HI_W = ADDR_W - LO_W;

    logic             stk_sel_q;
    logic             accept;
    logic [OFS_W-1:0] ofs;
    logic [ADDR_W-1:0] addr_nx;
    logic [1:0]       space_nx;

    // Stack-select bit: cleared by reset, loaded on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      stk_sel_q <= 1'b0;
        else if (sel_wr) stk_sel_q <= sel_val;
    end

    dpage_field_decode #(.OFS_W(OFS_W)) u_dec (
        .req_valid (req_valid),
        .instr_lo  (instr_lo),
        .accept    (accept),
        .ofs       (ofs)
    );

    dpage_addr_calc #(.OFS_W(OFS_W), .LO_W(LO_W), .ADDR_W(ADDR_W)) u_calc (
        .mode     (amode),
        .stk_sel  (stk_sel_q),
        .ofs      (ofs),
        .page_reg (page_reg),
        .stk_ptr  (stk_ptr),
        .io_page  (io_page),
        .ext_ptr  (ext_ptr),
        .addr_nx  (addr_nx),
        .space_nx (space_nx)
    );

    dpage_out_reg #(.ADDR_W(ADDR_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .addr_d  (addr_nx),
        .space_d (space_nx),
        .valid_q (addr_valid),
        .addr_q  (addr),
        .space_q (addr_space)
    );

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!addr_valid && !stk_sel_q)); // R1

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        sel_wr |=> stk_sel_q == $past(sel_val)); // R4

    AST_PAGE_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && amode == AM_DIRECT && !stk_sel_q)
        |=> addr[OFS_W-1:0] == $past(instr_lo[OFS_W-1:0])); // R2

    AST_STACK_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && amode == AM_DIRECT && stk_sel_q)
        |=> addr[ADDR_W-1:LO_W] == '0); // R3

    AST_EXT_PAGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && amode == AM_EXT)
        |=> addr[ADDR_W-1:LO_W] == $past(ext_ptr[ADDR_W-1:LO_W])); // R7

    AST_IO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && amode == AM_PERIPH) |=> addr_space == SPC_IO); // R6

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> addr_valid); // R9

    initial begin
        assert (HI_W >= 0) else $error("address narrower than low word");
    end
endmodule

// File: tb/sim_dpage_addr_gen.sv
module sim_dpage_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  instr_lo = '0;
    logic [1:0]  amode = '0;
    logic        sel_wr = 1'b0;
    logic        sel_val = 1'b0;
    logic [8:0]  page_reg = '0;
    logic [15:0] stk_ptr = '0;
    logic [8:0]  io_page = '0;
    logic [22:0] ext_ptr = '0;
    logic        addr_valid;
    logic [22:0] addr;
    logic [1:0]  addr_space;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        bit          v;
        logic [22:0] a;
        logic [1:0]  s;
        string       tag;
    } item_t;
    item_t q[$];

    bit          m_sel = 1'b0;
    logic [22:0] m_addr = '0;
    logic [1:0]  m_space = '0;

    always #4 clk = ~clk;

    dpage_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .instr_lo(instr_lo),
        .amode(amode), .sel_wr(sel_wr), .sel_val(sel_val), .page_reg(page_reg),
        .stk_ptr(stk_ptr), .io_page(io_page), .ext_ptr(ext_ptr),
        .addr_valid(addr_valid), .addr(addr), .addr_space(addr_space)
    );

    task automatic drive(input bit rv, input logic [7:0] ins, input logic [1:0] md,
                         input bit wr, input bit wv, input logic [8:0] pg,
                         input logic [15:0] sp, input logic [8:0] io,
                         input logic [22:0] ex, input string tag);
        item_t it;
        logic [15:0] o16;
        @(negedge clk);
        req_valid = rv; instr_lo = ins; amode = md; sel_wr = wr; sel_val = wv;
        page_reg = pg; stk_ptr = sp; io_page = io; ext_ptr = ex;
        o16 = {9'd0, ins[6:0]};
        it.v = rv && !ins[7];
        it.tag = tag;
        if (it.v) begin
            case (md)
                2'b00: begin
                    if (m_sel) begin m_addr = {7'd0, 16'(sp + o16)}; end
                    else       begin m_addr = {7'd0, pg, ins[6:0]}; end
                    m_space = 2'b00;
                end
                2'b01: begin m_addr = {16'd0, ins[6:0]}; m_space = 2'b01; end
                2'b10: begin m_addr = {7'd0, io, ins[6:0]}; m_space = 2'b10; end
                default: begin m_addr = {ex[22:16], 16'(ex[15:0] + o16)}; m_space = 2'b00; end
            endcase
        end
        it.a = m_addr;
        it.s = m_space;
        if (wr) m_sel = wv;
        q.push_back(it);
    endtask

    // Monitor: compare each produced cycle against the queued expectation.
    always @(posedge clk) begin
        item_t e;
        #2;
        if (q.size() > 0) begin
            e = q.pop_front();
            checks++;
            if (addr_valid !== e.v || addr !== e.a || addr_space !== e.s) begin
                errors++;
                $display("FAIL %s: actual v=%0b a=%06h s=%0d expected v=%0b a=%06h s=%0d",
                         e.tag, addr_valid, addr, addr_space, e.v, e.a, e.s);
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (addr_valid !== 1'b0 || addr !== 23'd0 || addr_space !== 2'd0) begin
            errors++;
            $display("FAIL R1 reset: actual v=%0b a=%06h s=%0d expected 0 0 0",
                     addr_valid, addr, addr_space);
        end
        @(negedge clk); rst_n = 1'b1;
        // R1 / R2: first request after reset uses page form; page 2 offset 1.
        drive(1, 8'h01, 2'b00, 0, 0, 9'd2, 16'h4000, 9'd0, 23'd0, "R1_R2 page2 ofs1");
        drive(1, 8'h7F, 2'b00, 0, 0, 9'h1FF, 16'h0, 9'd0, 23'd0, "R2 top page");
        drive(0, 8'h10, 2'b00, 0, 0, 9'd3, 16'h0, 9'd0, 23'd0, "R9 idle holds");
        // R8: marker bit set with no other change is rejected.
        drive(1, 8'h85, 2'b01, 0, 0, 9'd3, 16'h0, 9'd0, 23'd0, "R8 marker set");
        // R4: write and request in the same cycle; request sees old bit.
        drive(1, 8'h22, 2'b00, 1, 1, 9'd5, 16'h1234, 9'd0, 23'd0, "R4 same-cycle old bit");
        drive(1, 8'h10, 2'b00, 0, 0, 9'd5, 16'h1234, 9'd0, 23'd0, "R3 stack add");
        drive(1, 8'h7F, 2'b00, 0, 0, 9'd5, 16'hFFF0, 9'd0, 23'd0, "R3 stack wrap");
        drive(1, 8'hFF, 2'b00, 0, 0, 9'd5, 16'hFFF0, 9'd0, 23'd0, "R8 marker in stack mode");
        drive(1, 8'h5F, 2'b01, 0, 0, 9'h1AA, 16'hBEEF, 9'd7, 23'h7FFFFF, "R5 last register");
        drive(1, 8'h60, 2'b01, 0, 0, 9'h1AA, 16'hBEEF, 9'd7, 23'h7FFFFF, "R5 first scratch");
        drive(1, 8'h05, 2'b10, 0, 0, 9'd1, 16'h0, 9'h0AB, 23'd0, "R6 peripheral");
        drive(1, 8'h10, 2'b11, 0, 0, 9'd1, 16'h0, 9'd0, 23'h7FFFFA, "R7 ext wrap");
        drive(1, 8'h03, 2'b11, 0, 0, 9'd1, 16'h0, 9'd0, 23'h150100, "R7 ext plain");
        drive(0, 8'h00, 2'b00, 1, 0, 9'd0, 16'h0, 9'd0, 23'd0, "R4 clear bit idle");
        drive(1, 8'h01, 2'b00, 0, 0, 9'd2, 16'h7000, 9'd0, 23'd0, "R4 page after clear");
        drive(0, 8'h00, 2'b00, 0, 0, 9'd0, 16'h0, 9'd0, 23'd0, "R9 trailing idle");
        @(negedge clk); req_valid = 1'b0; sel_wr = 1'b0;
        wait (q.size() == 0);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule